// File: doc/BRIEF.md
# Wide Accumulator Register File with Multiply-Accumulate

This block holds a small bank of wide accumulators for a fixed-point signal-processing core, together with the arithmetic that feeds them. Each cycle the core may issue one operation. The operation names an opcode, two signed 16-bit operands, a source accumulator and a destination accumulator. The operations are load, wrapping add, clamping add, multiply and multiply-accumulate. The result is written back to the destination on the next clock edge.

Each accumulator has 40 bits. It is a 32-bit signed value with 8 extra headroom bits above it, so that long accumulation chains can run past the 32-bit range without losing the sign. A separate port writes the low, high or headroom field of any accumulator on its own. A combinational read port returns any single field or a whole accumulator.

Two status outputs are provided:
- An overflow flag reports whether the last written result fell outside the signed 32-bit range.
- A sticky flag records that a clamping add has clamped. It stays set until a clear input is pulsed.

Top module: `acc_datapath`

## Requirements
- R1: After reset every accumulator reads zero, and both the overflow flag and the saturation flag are low.
- R2: Each accumulator is split into three fields:
  - low: bits 15:0, field code 0
  - high: bits 31:16, field code 1
  - headroom: bits 39:32, field code 2, read zero-extended to 16 bits

  A field write changes only the addressed field. It takes the headroom value from the lowest 8 bits of the write data. A field read with code 3 returns zero.
- R3: Load (op code 1) writes the 32-bit value {op_a, op_b}, with op_a as the upper half, sign-extended to 40 bits into the destination.
- R4: Wrapping add (op code 2) writes source + sign-extended {op_a, op_b}, reduced modulo 2^40, into the destination.
- R5: Every writing operation sets ovf_flag to show whether its result lies outside the signed 32-bit range. For the clamping add, the unclamped sum is used. Cycles with no writing operation leave ovf_flag unchanged.
- R6: Clamping add (op code 3) computes the exact sum as in R4. A sum above 2^31-1 writes 0x007FFFFFFF. A sum below -2^31 writes 0xFF80000000. Any other sum is written unchanged.
- R7: sat_flag goes high after a clamping add that clamped, and stays high until sat_clr is pulsed. If a clamp and sat_clr occur in the same cycle, the flag stays set.
- R8: Multiply (op code 4) writes the signed 16x16 product of op_a and op_b, sign-extended to 40 bits, into the destination.
- R9: Multiply-accumulate (op code 5) writes source + sign-extended product, modulo 2^40, into the destination. The source is left unchanged when it differs from the destination.
- R10: A requested write becomes visible at the clock edge that accepts it. Reads during the request cycle return the old value. Accumulators other than the destination keep their values.
- R11: Op codes 0, 6 and 7, or op_valid low, change no accumulator and no flag.
- R12: When an operation and a field write target the same accumulator in the same cycle, only the operation result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request this cycle |
| op_code | input | 3 | Operation code |
| op_a | input | 16 | First signed operand |
| op_b | input | 16 | Second signed operand |
| src_sel | input | 2 | Source accumulator index |
| dst_sel | input | 2 | Destination accumulator index |
| fw_en | input | 1 | Field write enable |
| fw_idx | input | 2 | Field write accumulator index |
| fw_field | input | 2 | Field code for the write |
| fw_data | input | 16 | Field write data |
| rd_idx | input | 2 | Read accumulator index |
| rd_field | input | 2 | Field code for the read |
| rd_data | output | 16 | Selected field of the read accumulator |
| rd_acc | output | 40 | Whole read accumulator |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| ovf_flag | output | 1 | Last result outside the signed 32-bit range |
| sat_flag | output | 1 | Sticky clamp indicator |

## Verification
The embedded properties assume several things about the inputs:
- rst_n is held low across the first clock edges.
- op_code, the indices and the field codes are never unknown while reset is released.
- A clamping add is the only way the sticky flag can rise.

The directed stimulus keeps within these assumptions. It drives every input to a defined value at time zero. It changes inputs only on falling edges and issues at most one operation and one field write per cycle. It covers:
- clamping at both limits
- wrapping at the 40-bit boundary
- an operation and a field write on the same accumulator, which is the only intended collision.

// File: rtl/acc_pkg.sv
package acc_pkg;

   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_LOAD = 3'd1,
      OP_ADD  = 3'd2,
      OP_SADD = 3'd3,
      OP_MPY  = 3'd4,
      OP_MAC  = 3'd5
   } acc_op_e;

   typedef enum logic [1:0] {
      FLD_LO = 2'd0,
      FLD_HI = 2'd1,
      FLD_GD = 2'd2
   } acc_fld_e;

endpackage

// File: rtl/acc_sat.sv
module acc_sat #(
   parameter int OPW   = 16,
   parameter int GUARD = 8,
   localparam int ACCW = 2*OPW + GUARD,
   localparam int SUMW = ACCW + 1
) (
   input  logic [SUMW-1:0] sum_x,
   output logic [ACCW-1:0] sat_val,
   output logic            hit
);
   localparam logic [ACCW-1:0] MAXV = {{(GUARD+1){1'b0}}, {(2*OPW-1){1'b1}}};
   localparam logic [ACCW-1:0] MINV = {{(GUARD+1){1'b1}}, {(2*OPW-1){1'b0}}};

   logic pos_over, neg_over;

   // Bits above the 32-bit sign position must all equal the true sign bit
   assign pos_over = !sum_x[SUMW-1] && (|sum_x[SUMW-2:2*OPW-1]);
   assign neg_over =  sum_x[SUMW-1] && !(&sum_x[SUMW-2:2*OPW-1]);
   assign hit      = pos_over || neg_over;

   always_comb begin
      if (pos_over)      sat_val = MAXV;
      else if (neg_over) sat_val = MINV;
      else               sat_val = sum_x[ACCW-1:0];
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_pkg::*;
#(
   parameter int OPW    = 16,
   parameter int GUARD  = 8,
   parameter bit SAT_EN = 1'b1,
   localparam int ACCW  = 2*OPW + GUARD,
   localparam int SUMW  = ACCW + 1
) (
   input  logic            op_valid,
   input  logic [2:0]      op,
   input  logic [OPW-1:0]  a,
   input  logic [OPW-1:0]  b,
   input  logic [ACCW-1:0] src_val,
   output logic            wr_en,
   output logic [ACCW-1:0] result,
   output logic            ovf,
   output logic            sat_hit
);
   logic signed [2*OPW-1:0] prod;
   logic [ACCW-1:0] ext_ab, ext_p, addend, wrap, sat_val;
   logic [SUMW-1:0] sum_x;
   logic            clamp, writes;

   assign prod   = $signed(a) * $signed(b);
   assign ext_ab = {{GUARD{a[OPW-1]}}, a, b};
   assign ext_p  = {{GUARD{prod[2*OPW-1]}}, prod};
   assign addend = (op == OP_MAC) ? ext_p : ext_ab;
   assign sum_x  = {src_val[ACCW-1], src_val} + {addend[ACCW-1], addend};
   assign wrap   = sum_x[ACCW-1:0];

   generate
      if (SAT_EN) begin : g_clamp
         acc_sat #(.OPW(OPW), .GUARD(GUARD)) u_sat (
            .sum_x  (sum_x),
            .sat_val(sat_val),
            .hit    (clamp)
         );
      end else begin : g_noclamp
         assign sat_val = wrap;
         assign clamp   = 1'b0;
      end
   endgenerate

   always_comb begin
      writes = 1'b1;
      case (op)
         OP_LOAD: result = ext_ab;
         OP_ADD:  result = wrap;
         OP_SADD: result = sat_val;
         OP_MPY:  result = ext_p;
         OP_MAC:  result = wrap;
         default: begin
            result = '0;
            writes = 1'b0;
         end
      endcase
   end

   assign wr_en   = op_valid && writes;
   assign sat_hit = op_valid && (op == OP_SADD) && clamp;

   always_comb begin
      if (op == OP_SADD)
         ovf = (|sum_x[SUMW-1:2*OPW-1]) && !(&sum_x[SUMW-1:2*OPW-1]);
      else
         ovf = (|result[ACCW-1:2*OPW-1]) && !(&result[ACCW-1:2*OPW-1]);
   end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile
   import acc_pkg::*;
#(
   parameter int N_ACC = 4,
   parameter int OPW   = 16,
   parameter int GUARD = 8,
   localparam int ACCW = 2*OPW + GUARD,
   localparam int IDXW = $clog2(N_ACC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [IDXW-1:0] wr_idx,
   input  logic [ACCW-1:0] wr_val,
   input  logic            fw_en,
   input  logic [IDXW-1:0] fw_idx,
   input  logic [1:0]      fw_field,
   input  logic [OPW-1:0]  fw_data,
   input  logic [IDXW-1:0] src_idx,
   output logic [ACCW-1:0] src_val,
   input  logic [IDXW-1:0] rd_idx,
   input  logic [1:0]      rd_field,
   output logic [OPW-1:0]  rd_data,
   output logic [ACCW-1:0] rd_acc
);
   logic [N_ACC-1:0][ACCW-1:0] acc_q;

   generate
      for (genvar g = 0; g < N_ACC; g++) begin : g_acc
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               acc_q[g] <= '0;
            end else if (wr_en && wr_idx == IDXW'(g)) begin
               acc_q[g] <= wr_val;
            end else if (fw_en && fw_idx == IDXW'(g)) begin
               case (fw_field)
                  FLD_LO:  acc_q[g][OPW-1:0]      <= fw_data;
                  FLD_HI:  acc_q[g][2*OPW-1:OPW]  <= fw_data;
                  FLD_GD:  acc_q[g][ACCW-1:2*OPW] <= fw_data[GUARD-1:0];
                  default: ;
               endcase
            end
         end
      end
   endgenerate

   assign src_val = acc_q[src_idx];
   assign rd_acc  = acc_q[rd_idx];

   always_comb begin
      case (rd_field)
         FLD_LO:  rd_data = acc_q[rd_idx][OPW-1:0];
         FLD_HI:  rd_data = acc_q[rd_idx][2*OPW-1:OPW];
         FLD_GD:  rd_data = {{(OPW-GUARD){1'b0}}, acc_q[rd_idx][ACCW-1:2*OPW]};
         default: rd_data = '0;
      endcase
   end

   // R2: a low-field write leaves the upper fields of that accumulator intact
   p_fld_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_en && fw_field == FLD_LO && !(wr_en && wr_idx == fw_idx))
      |=> acc_q[$past(fw_idx)][ACCW-1:OPW] == $past(acc_q[fw_idx][ACCW-1:OPW]));

   // R11: with no write of any kind the bank holds its contents
   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !fw_en) |=> $stable(acc_q));

   // R12: an operation result beats a field write to the same accumulator
   p_op_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && fw_en && wr_idx == fw_idx)
      |=> acc_q[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
   import acc_pkg::*;
#(
   parameter int N_ACC  = 4,
   parameter int OPW    = 16,
   parameter int GUARD  = 8,
   parameter bit SAT_EN = 1'b1,
   localparam int ACCW  = 2*OPW + GUARD,
   localparam int IDXW  = $clog2(N_ACC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_valid,
   input  logic [2:0]      op_code,
   input  logic [OPW-1:0]  op_a,
   input  logic [OPW-1:0]  op_b,
   input  logic [IDXW-1:0] src_sel,
   input  logic [IDXW-1:0] dst_sel,
   input  logic            fw_en,
   input  logic [IDXW-1:0] fw_idx,
   input  logic [1:0]      fw_field,
   input  logic [OPW-1:0]  fw_data,
   input  logic [IDXW-1:0] rd_idx,
   input  logic [1:0]      rd_field,
   output logic [OPW-1:0]  rd_data,
   output logic [ACCW-1:0] rd_acc,
   input  logic            sat_clr,
   output logic            ovf_flag,
   output logic            sat_flag
);
   generate
      if (N_ACC < 2 || (N_ACC & (N_ACC - 1)) != 0) begin : g_bad_nacc
         $error("acc_datapath: N_ACC must be a power of two, at least 2");
      end
      if (GUARD < 1 || GUARD > OPW) begin : g_bad_guard
         $error("acc_datapath: GUARD must lie in 1..OPW");
      end
      if (OPW < 2) begin : g_bad_opw
         $error("acc_datapath: OPW must be at least 2");
      end
   endgenerate

   logic [ACCW-1:0] src_val, alu_res;
   logic            alu_wr, alu_ovf, alu_sat;
   logic            ovf_q, sat_q;

   acc_regfile #(.N_ACC(N_ACC), .OPW(OPW), .GUARD(GUARD)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (alu_wr),
      .wr_idx  (dst_sel),
      .wr_val  (alu_res),
      .fw_en   (fw_en),
      .fw_idx  (fw_idx),
      .fw_field(fw_field),
      .fw_data (fw_data),
      .src_idx (src_sel),
      .src_val (src_val),
      .rd_idx  (rd_idx),
      .rd_field(rd_field),
      .rd_data (rd_data),
      .rd_acc  (rd_acc)
   );

   acc_alu #(.OPW(OPW), .GUARD(GUARD), .SAT_EN(SAT_EN)) u_alu (
      .op_valid(op_valid),
      .op      (op_code),
      .a       (op_a),
      .b       (op_b),
      .src_val (src_val),
      .wr_en   (alu_wr),
      .result  (alu_res),
      .ovf     (alu_ovf),
      .sat_hit (alu_sat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         sat_q <= 1'b0;
      end else begin
         if (alu_wr) ovf_q <= alu_ovf;
         sat_q <= (sat_q && !sat_clr) || alu_sat;
      end
   end

   assign ovf_flag = ovf_q;
   assign sat_flag = sat_q;

   // R6: a clamping add never hands the bank a value outside 32-bit range
   p_sadd_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_wr && op_code == OP_SADD && SAT_EN)
      |-> (&alu_res[ACCW-1:2*OPW-1]) || !(|alu_res[ACCW-1:2*OPW-1]));

   // R7: the sticky flag survives until cleared
   p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_q && !sat_clr) |=> sat_q);

   // R7: only a clamping add can raise the sticky flag
   p_sat_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sat_q) |-> $past(op_valid && op_code == OP_SADD));

   // R5: overflow status is held across cycles without a writing operation
   p_ovf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !alu_wr |=> $stable(ovf_q));
endmodule

// File: tb/acc_datapath_test.sv
module acc_datapath_test;
   logic        clk, rst_n;
   logic        op_valid, fw_en, sat_clr;
   logic [2:0]  op_code;
   logic [15:0] op_a, op_b, fw_data, rd_data;
   logic [1:0]  src_sel, dst_sel, fw_idx, fw_field, rd_idx, rd_field;
   logic [39:0] rd_acc;
   logic        ovf_flag, sat_flag;
   int checks = 0, fails = 0;
   bit done = 0;

   acc_datapath uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_a(op_a), .op_b(op_b), .src_sel(src_sel), .dst_sel(dst_sel),
      .fw_en(fw_en), .fw_idx(fw_idx), .fw_field(fw_field), .fw_data(fw_data),
      .rd_idx(rd_idx), .rd_field(rd_field), .rd_data(rd_data), .rd_acc(rd_acc),
      .sat_clr(sat_clr), .ovf_flag(ovf_flag), .sat_flag(sat_flag)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   task automatic chk(input string tag, input logic [39:0] got, input logic [39:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                        input logic [1:0] s, input logic [1:0] d, input logic clr = 1'b0);
      @(negedge clk);
      op_valid = 1'b1; op_code = op; op_a = a; op_b = b;
      src_sel = s; dst_sel = d; sat_clr = clr;
      @(negedge clk);
      op_valid = 1'b0; op_code = 3'd0; sat_clr = 1'b0;
   endtask

   task automatic fwrite(input logic [1:0] idx, input logic [1:0] fld, input logic [15:0] data);
      @(negedge clk);
      fw_en = 1'b1; fw_idx = idx; fw_field = fld; fw_data = data;
      @(negedge clk);
      fw_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] idx, output logic [39:0] v);
      rd_idx = idx;
      #1 v = rd_acc;
   endtask

   task automatic pulse_clr();
      @(negedge clk); sat_clr = 1'b1;
      @(negedge clk); sat_clr = 1'b0;
   endtask

   task automatic t_reset();
      logic [39:0] v;
      for (int i = 0; i < 4; i++) begin
         rd(2'(i), v);
         chk($sformatf("R1 acc%0d after reset", i), v, 40'h0);
      end
      chk("R1 ovf after reset", {39'h0, ovf_flag}, 40'h0);
      chk("R1 sat after reset", {39'h0, sat_flag}, 40'h0);
   endtask

   task automatic t_load();
      logic [39:0] v;
      issue(3'd1, 16'h8000, 16'h0001, 2'd0, 2'd1);
      rd(2'd1, v); chk("R3 load negative", v, 40'hFF80000001);
      issue(3'd1, 16'h1234, 16'h5678, 2'd0, 2'd2);
      rd(2'd2, v); chk("R3 load positive", v, 40'h0012345678);
      chk("R5 ovf after load", {39'h0, ovf_flag}, 40'h0);
   endtask

   task automatic t_fields();
      logic [39:0] v;
      fwrite(2'd0, 2'd0, 16'hBEEF);
      fwrite(2'd0, 2'd1, 16'hCAFE);
      fwrite(2'd0, 2'd2, 16'hFF5A);
      rd(2'd0, v); chk("R2 fields assembled", v, 40'h5ACAFEBEEF);
      rd_field = 2'd0; #1 chk("R2 read low", {24'h0, rd_data}, 40'hBEEF);
      rd_field = 2'd1; #1 chk("R2 read high", {24'h0, rd_data}, 40'hCAFE);
      rd_field = 2'd2; #1 chk("R2 read headroom", {24'h0, rd_data}, 40'h005A);
      rd_field = 2'd3; #1 chk("R2 read code 3", {24'h0, rd_data}, 40'h0);
      fwrite(2'd0, 2'd1, 16'h1111);
      rd(2'd0, v); chk("R2 high rewrite only", v, 40'h5A1111BEEF);
   endtask

   task automatic t_add();
      logic [39:0] v;
      issue(3'd1, 16'h7FFF, 16'hFFFF, 2'd0, 2'd0);
      issue(3'd2, 16'h0000, 16'h0001, 2'd0, 2'd1);
      rd(2'd1, v); chk("R4 add past 32 bits", v, 40'h0080000000);
      chk("R5 ovf set by add", {39'h0, ovf_flag}, 40'h1);
      @(negedge clk);
      chk("R5 ovf held idle", {39'h0, ovf_flag}, 40'h1);
      issue(3'd1, 16'h0000, 16'h0005, 2'd0, 2'd2);
      issue(3'd2, 16'h0000, 16'h0007, 2'd2, 2'd2);
      rd(2'd2, v); chk("R4 small add", v, 40'd12);
      chk("R5 ovf clear in range", {39'h0, ovf_flag}, 40'h0);
      issue(3'd2, 16'hFFFF, 16'hFFFE, 2'd2, 2'd0);
      rd(2'd0, v); chk("R4 add negative", v, 40'd10);
      fwrite(2'd3, 2'd2, 16'h007F);
      fwrite(2'd3, 2'd1, 16'hFFFF);
      fwrite(2'd3, 2'd0, 16'hFFFF);
      issue(3'd2, 16'h0000, 16'h0001, 2'd3, 2'd3);
      rd(2'd3, v); chk("R4 wrap at 40 bits", v, 40'h8000000000);
      chk("R5 ovf on wrap", {39'h0, ovf_flag}, 40'h1);
   endtask

   task automatic t_sadd();
      logic [39:0] v;
      issue(3'd1, 16'h7FFF, 16'hFFFF, 2'd0, 2'd0);
      issue(3'd3, 16'h0000, 16'h0001, 2'd0, 2'd1);
      rd(2'd1, v); chk("R6 clamp high", v, 40'h007FFFFFFF);
      chk("R5 ovf on clamp", {39'h0, ovf_flag}, 40'h1);
      chk("R7 sat set", {39'h0, sat_flag}, 40'h1);
      issue(3'd2, 16'h0000, 16'h0001, 2'd2, 2'd2);
      chk("R7 sat sticky", {39'h0, sat_flag}, 40'h1);
      pulse_clr();
      chk("R7 sat cleared", {39'h0, sat_flag}, 40'h0);
      issue(3'd1, 16'h8000, 16'h0000, 2'd0, 2'd2);
      issue(3'd3, 16'hFFFF, 16'hFFFF, 2'd2, 2'd2, 1'b1);
      rd(2'd2, v); chk("R6 clamp low", v, 40'hFF80000000);
      chk("R7 set beats clear", {39'h0, sat_flag}, 40'h1);
      pulse_clr();
      issue(3'd1, 16'h0000, 16'd12, 2'd0, 2'd3);
      issue(3'd3, 16'h0000, 16'd3, 2'd3, 2'd3);
      rd(2'd3, v); chk("R6 in-range sadd", v, 40'd15);
      chk("R7 no sat in range", {39'h0, sat_flag}, 40'h0);
      chk("R5 no ovf in range", {39'h0, ovf_flag}, 40'h0);
      fwrite(2'd0, 2'd2, 16'h0001);
      fwrite(2'd0, 2'd1, 16'h0000);
      fwrite(2'd0, 2'd0, 16'h0000);
      issue(3'd3, 16'h0000, 16'h0000, 2'd0, 2'd1);
      rd(2'd1, v); chk("R6 clamp from headroom", v, 40'h007FFFFFFF);
      pulse_clr();
   endtask

   task automatic t_mpy();
      logic [39:0] v;
      issue(3'd4, 16'd3, 16'hFFFC, 2'd0, 2'd0);
      rd(2'd0, v); chk("R8 3*-4", v, 40'hFFFFFFFFF4);
      issue(3'd4, 16'h8000, 16'h8000, 2'd0, 2'd1);
      rd(2'd1, v); chk("R8 min*min", v, 40'h0040000000);
      issue(3'd4, 16'h7FFF, 16'h8000, 2'd0, 2'd2);
      rd(2'd2, v); chk("R8 max*min", v, 40'hFFC0008000);
   endtask

   task automatic t_mac();
      logic [39:0] v;
      issue(3'd1, 16'h0000, 16'd100, 2'd0, 2'd1);
      issue(3'd5, 16'd7, 16'd6, 2'd1, 2'd2);
      rd(2'd2, v); chk("R9 mac positive", v, 40'd142);
      rd(2'd1, v); chk("R9 source kept", v, 40'd100);
      issue(3'd5, 16'hFFFF, 16'd3, 2'd2, 2'd2);
      rd(2'd2, v); chk("R9 mac negative", v, 40'd139);
      fwrite(2'd3, 2'd2, 16'h007F);
      fwrite(2'd3, 2'd1, 16'hFFFF);
      fwrite(2'd3, 2'd0, 16'hFFFF);
      issue(3'd5, 16'd1, 16'd1, 2'd3, 2'd0);
      rd(2'd0, v); chk("R9 mac wrap", v, 40'h8000000000);
      chk("R5 ovf after mac wrap", {39'h0, ovf_flag}, 40'h1);
   endtask

   task automatic t_timing();
      logic [39:0] v;
      issue(3'd1, 16'h0000, 16'h0042, 2'd0, 2'd2);
      @(negedge clk);
      op_valid = 1'b1; op_code = 3'd1; op_a = 16'h0000; op_b = 16'h0099; dst_sel = 2'd2;
      rd_idx = 2'd2;
      #1 chk("R10 old value in request cycle", rd_acc, 40'h42);
      @(posedge clk);
      #1 chk("R10 new value after edge", rd_acc, 40'h99);
      op_valid = 1'b0; op_code = 3'd0;
      rd(2'd1, v); chk("R10 other acc untouched", v, 40'd100);
   endtask

   task automatic t_nop();
      logic [39:0] v;
      issue(3'd1, 16'h0000, 16'h0777, 2'd0, 2'd0);
      issue(3'd2, 16'h7FFF, 16'hFFFF, 2'd0, 2'd1);
      issue(3'd0, 16'h1234, 16'h1234, 2'd1, 2'd0);
      issue(3'd6, 16'h1234, 16'h1234, 2'd1, 2'd0);
      issue(3'd7, 16'h1234, 16'h1234, 2'd1, 2'd0);
      rd(2'd0, v); chk("R11 codes 0/6/7 ignored", v, 40'h777);
      chk("R11 ovf unchanged", {39'h0, ovf_flag}, 40'h1);
      @(negedge clk);
      op_valid = 1'b0; op_code = 3'd1; op_a = 16'h5555; op_b = 16'h5555; dst_sel = 2'd0;
      @(negedge clk);
      op_code = 3'd0;
      rd(2'd0, v); chk("R11 op_valid low ignored", v, 40'h777);
   endtask

   task automatic t_collide();
      logic [39:0] v;
      @(negedge clk);
      op_valid = 1'b1; op_code = 3'd1; op_a = 16'h0000; op_b = 16'h1234; dst_sel = 2'd3;
      fw_en = 1'b1; fw_idx = 2'd3; fw_field = 2'd0; fw_data = 16'hAAAA;
      @(negedge clk);
      op_valid = 1'b0; op_code = 3'd0; fw_en = 1'b0;
      rd(2'd3, v); chk("R12 operation wins", v, 40'h0000001234);
   endtask

   initial begin
      rst_n = 1'b0; op_valid = 1'b0; op_code = 3'd0; op_a = '0; op_b = '0;
      src_sel = '0; dst_sel = '0; fw_en = 1'b0; fw_idx = '0; fw_field = '0;
      fw_data = '0; rd_idx = '0; rd_field = '0; sat_clr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load();
      t_fields();
      t_add();
      t_sadd();
      t_mpy();
      t_mac();
      t_timing();
      t_nop();
      t_collide();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #4_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired got=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule